// File: doc/BRIEF.md
# Four-Line Instruction Cache with Queue Replacement

This block sits between a processor core and a shared hub memory and keeps recently executed code close to the core. It holds four lines. Each line is one wide of eight 32-bit longs, and any wide can be placed in any line. The core presents a long-aligned hub address on the fetch port. On a hit, the instruction comes back combinationally in the same cycle. On a miss, the core is stalled. The cache then asks a hub-side engine for the whole wide and takes the eight longs as they arrive, in order, with gaps allowed.

In the shared mode, all four lines form one pool. Their replacement order is kept in an 8-bit register that works as a queue of four 2-bit line numbers. The bottom entry names the victim. A load rotates the victim to the top of the queue, and a hit moves the line that hit to the top. Starting from reset, loads go round-robin.

In the split mode, each of four tasks owns one line, namely the line whose number equals the task number. A task looks up and replaces only that line, and the queue plays no part.

Top module: `icache_queue_lru`

## Requirements
- R1: On a hit, fetch_data is the long of the matched line selected by fetch_addr[2:0], and it is valid in the same cycle as fetch_hit.
- R2: After reset, every line is invalid, so the first fetch of any wide misses. The replacement queue reads 8'b11100100, with line 0 at the bottom (bits 1:0) and line 3 at the top (bits 7:6). fill_req is low.
- R3: A miss asserts fetch_stall. In the following cycle, fill_req rises with fill_wide_addr equal to fetch_addr >> 3. Both hold steady until eight longs have been accepted on cycles with fill_valid high. The longs arrive in offset order 0 to 7.
- R4: A line under fill is treated as invalid. A fetch that hits after a miss always returns the fully loaded long.
- R5: In shared mode, a load takes the line at the bottom of the queue and rotates that line number to the top. From reset, with no hits in between, loads use lines 0, 1, 2, 3 in that order, and the fifth load evicts the first wide loaded.
- R6: In shared mode, a hit moves the line that hit to the top of the queue. A later miss therefore evicts the least recently used wide.
- R7: In split mode (split_mode=1), task t (fetch_task=t) looks up and replaces only line t. A wide held in another task's line does not produce a hit.
- R8: In shared mode, no two lines ever match the same address.
- R9: fetch_hit is asserted only while fetch_valid is high. fetch_stall equals fetch_valid with no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1: one line per task; 0: shared queue-ordered pool |
| fetch_valid | input | 1 | Fetch request present |
| fetch_task | input | 2 | Requesting task number (used in split mode) |
| fetch_addr | input | ADDR_W | Long address in hub memory |
| fetch_hit | output | 1 | Instruction is valid on fetch_data |
| fetch_stall | output | 1 | Request missed; hold it |
| fetch_data | output | DATA_W | Instruction long |
| fill_req | output | 1 | Wide fill in progress |
| fill_wide_addr | output | ADDR_W-3 | Wide address being filled |
| fill_valid | input | 1 | One long of the wide is on fill_data |
| fill_data | input | DATA_W | Long from hub, offsets in ascending order |

## Verification
The bench uses the default parameters: 16-bit long addresses, eight-long lines, and 13-bit wide tags. Working sets of five or six wides are more than the four lines can hold, so a sweep of a few hundred fetches drives the cache through eviction over and over in both modes. A bench-side queue model predicts every hit or miss under these sets. The responder inserts a gap in the middle of each fill, which exercises the fill counter's handling of idle cycles.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int NUM_LINES = 4;
    localparam int ID_W      = 2;

    typedef logic [ID_W-1:0] line_id_t;
    // entry 0 (bits 1:0) is the bottom = least recently used
    typedef line_id_t [NUM_LINES-1:0] lru_queue_t;

    localparam lru_queue_t LRU_RESET = 8'b11100100;

    typedef enum logic {FILL_IDLE = 1'b0, FILL_BUSY = 1'b1} fill_state_e;

    typedef struct packed {
        logic     hit;
        line_id_t id;
    } lookup_t;

    // victim leaves the bottom and re-enters at the top
    function automatic lru_queue_t lru_rotate(input lru_queue_t q);
        return {q[0], q[NUM_LINES-1:1]};
    endfunction

    // pull the used line out of its slot and put it on top
    function automatic lru_queue_t lru_touch(input lru_queue_t q, input line_id_t id);
        lru_queue_t r;
        logic       found;
        found = 1'b0;
        for (int i = 0; i < NUM_LINES - 1; i++) begin
            if (q[i] == id) found = 1'b1;
            r[i] = found ? q[i+1] : q[i];
        end
        r[NUM_LINES-1] = id;
        return r;
    endfunction

endpackage

// File: rtl/icache_lru_queue.sv
module icache_lru_queue
    import icache_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  logic       touch_en,
    input  line_id_t   touch_id,
    output lru_queue_t queue_o
);
    lru_queue_t q;

    always_ff @(posedge clk) begin
        if (rst)           q <= LRU_RESET;
        else if (load_en)  q <= lru_rotate(q);
        else if (touch_en) q <= lru_touch(q, touch_id);
    end

    assign queue_o = q;
endmodule

// File: rtl/icache_tag_array.sv
module icache_tag_array
    import icache_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TAG_W-1:0]     lookup_tag,
    input  logic                 split_mode,
    input  line_id_t             task_id,
    input  logic                 inval_en,
    input  line_id_t             inval_id,
    input  logic [TAG_W-1:0]     inval_tag,
    input  logic                 set_valid_en,
    input  line_id_t             set_valid_id,
    output logic [NUM_LINES-1:0] hit_vec,
    output lookup_t              result
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[l] <= 1'b0;
                tag_q[l]   <= '0;
            end else if (inval_en && inval_id == line_id_t'(l)) begin
                valid_q[l] <= 1'b0;
                tag_q[l]   <= inval_tag;
            end else if (set_valid_en && set_valid_id == line_id_t'(l)) begin
                valid_q[l] <= 1'b1;
            end
        end

        assign hit_vec[l] = valid_q[l] && (tag_q[l] == lookup_tag)
                            && (!split_mode || task_id == line_id_t'(l));
    end

    always_comb begin
        result.hit = |hit_vec;
        result.id  = '0;
        for (int l = 0; l < NUM_LINES; l++)
            if (hit_vec[l]) result.id = line_id_t'(l);
    end
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store
    import icache_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 3,
    localparam int LONGS = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  line_id_t          wr_line,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  line_id_t          rd_line,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NUM_LINES][LONGS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_line][wr_off] <= wr_data;
    end

    assign rd_data = mem[rd_line][rd_off];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int TAG_W = 13,
    parameter int OFF_W = 3,
    localparam logic [OFF_W-1:0] LAST = {OFF_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  line_id_t         start_line,
    input  logic [TAG_W-1:0] start_tag,
    input  logic             fill_valid,
    output logic             busy,
    output logic             fill_req,
    output logic [TAG_W-1:0] fill_tag,
    output logic             wr_en,
    output line_id_t         wr_line,
    output logic [OFF_W-1:0] wr_off,
    output logic             done
);
    fill_state_e      state;
    logic [OFF_W-1:0] cnt;
    line_id_t         line_q;
    logic [TAG_W-1:0] tag_q;

    assign busy     = (state == FILL_BUSY);
    assign fill_req = busy;
    assign fill_tag = tag_q;
    assign wr_en    = busy && fill_valid;
    assign wr_line  = line_q;
    assign wr_off   = cnt;
    assign done     = wr_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FILL_IDLE;
            cnt    <= '0;
            line_q <= '0;
            tag_q  <= '0;
        end else begin
            case (state)
                FILL_IDLE: if (start) begin
                    state  <= FILL_BUSY;
                    cnt    <= '0;
                    line_q <= start_line;
                    tag_q  <= start_tag;
                end
                FILL_BUSY: if (wr_en) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= FILL_IDLE;
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/icache_queue_lru.sv
module icache_queue_lru
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_LONGS = 8,
    localparam int OFF_W     = $clog2(LINE_LONGS),
    localparam int TAG_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              split_mode,
    input  logic              fetch_valid,
    input  logic [1:0]        fetch_task,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_hit,
    output logic              fetch_stall,
    output logic [DATA_W-1:0] fetch_data,
    output logic              fill_req,
    output logic [TAG_W-1:0]  fill_wide_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    logic [TAG_W-1:0]     req_tag;
    logic [OFF_W-1:0]     req_off;
    logic [NUM_LINES-1:0] hit_vec;
    lookup_t              look;
    lru_queue_t           lru_q;
    line_id_t             victim;
    logic                 busy, miss_start, done;
    logic                 wr_en;
    line_id_t             wr_line;
    logic [OFF_W-1:0]     wr_off;

    assign req_tag = fetch_addr[ADDR_W-1:OFF_W];
    assign req_off = fetch_addr[OFF_W-1:0];

    assign fetch_hit   = fetch_valid && look.hit;
    assign fetch_stall = fetch_valid && !look.hit;
    assign miss_start  = fetch_stall && !busy;
    assign victim      = split_mode ? line_id_t'(fetch_task) : lru_q[0];

    icache_tag_array #(.TAG_W(TAG_W)) tags_i (
        .clk          (clk),
        .rst          (rst),
        .lookup_tag   (req_tag),
        .split_mode   (split_mode),
        .task_id      (line_id_t'(fetch_task)),
        .inval_en     (miss_start),
        .inval_id     (victim),
        .inval_tag    (req_tag),
        .set_valid_en (done),
        .set_valid_id (wr_line),
        .hit_vec      (hit_vec),
        .result       (look)
    );

    icache_lru_queue lru_i (
        .clk      (clk),
        .rst      (rst),
        .load_en  (miss_start && !split_mode),
        .touch_en (fetch_hit && !split_mode),
        .touch_id (look.id),
        .queue_o  (lru_q)
    );

    icache_fill_ctrl #(.TAG_W(TAG_W), .OFF_W(OFF_W)) fill_i (
        .clk        (clk),
        .rst        (rst),
        .start      (miss_start),
        .start_line (victim),
        .start_tag  (req_tag),
        .fill_valid (fill_valid),
        .busy       (busy),
        .fill_req   (fill_req),
        .fill_tag   (fill_wide_addr),
        .wr_en      (wr_en),
        .wr_line    (wr_line),
        .wr_off     (wr_off),
        .done       (done)
    );

    icache_data_store #(.DATA_W(DATA_W), .OFF_W(OFF_W)) data_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_line (wr_line),
        .wr_off  (wr_off),
        .wr_data (fill_data),
        .rd_line (look.id),
        .rd_off  (req_off),
        .rd_data (fetch_data)
    );
endmodule

// File: rtl/icache_queue_lru_chk.sv
module icache_queue_lru_chk
    import icache_pkg::*;
#(
    parameter int TAG_W      = 13,
    parameter int LINE_LONGS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 split_mode,
    input logic                 fetch_valid,
    input logic                 fetch_hit,
    input logic                 fetch_stall,
    input logic                 fill_req,
    input logic                 fill_valid,
    input logic [TAG_W-1:0]     fill_wide_addr,
    input logic [NUM_LINES-1:0] hit_vec,
    input lru_queue_t           lru_q
);
    int unsigned beats;
    always_ff @(posedge clk) begin
        if (rst || !fill_req) beats <= 0;
        else if (fill_valid)  beats <= beats + 1;
    end

    // R2
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!fill_req && lru_q == 8'b11100100));
    // R3
    fill_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_req) |-> $past(fetch_stall));
    // R3
    fill_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && $past(fill_req)) |-> $stable(fill_wide_addr));
    // R3
    fill_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fill_req) |-> ($past(fill_valid) && $past(beats) == LINE_LONGS - 1));
    // R9
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_hit |-> (fetch_valid && !fetch_stall));
    // R8
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        !split_mode |-> $onehot0(hit_vec));
    // R5
    queue_perm_chk: assert property (@(posedge clk) disable iff (rst)
        ((4'b1 << lru_q[0]) | (4'b1 << lru_q[1]) | (4'b1 << lru_q[2]) | (4'b1 << lru_q[3])) == 4'hF);
endmodule

bind icache_queue_lru icache_queue_lru_chk #(.TAG_W(TAG_W), .LINE_LONGS(LINE_LONGS)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .split_mode     (split_mode),
    .fetch_valid    (fetch_valid),
    .fetch_hit      (fetch_hit),
    .fetch_stall    (fetch_stall),
    .fill_req       (fill_req),
    .fill_valid     (fill_valid),
    .fill_wide_addr (fill_wide_addr),
    .hit_vec        (hit_vec),
    .lru_q          (lru_q)
);

// File: tb/icache_queue_lru_tb_top.sv
module icache_queue_lru_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int TAG_W  = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              split_mode = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [1:0]        fetch_task = '0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic              fetch_hit, fetch_stall, fill_req;
    logic [DATA_W-1:0] fetch_data;
    logic [TAG_W-1:0]  fill_wide_addr;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    icache_queue_lru #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_LONGS(8)) dut_i (
        .clk(clk), .rst(rst), .split_mode(split_mode),
        .fetch_valid(fetch_valid), .fetch_task(fetch_task), .fetch_addr(fetch_addr),
        .fetch_hit(fetch_hit), .fetch_stall(fetch_stall), .fetch_data(fetch_data),
        .fill_req(fill_req), .fill_wide_addr(fill_wide_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] hub_word(input int a);
        return 32'(a) * 32'h9E3779B1 + 32'h1234_5678;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // hub responder: eight longs in order, with one idle gap
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                int base;
                base = int'(fill_wide_addr) * 8;
                @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    if (i == 3) begin
                        fill_valid = 1'b0;
                        @(negedge clk);
                    end
                    fill_valid = 1'b1;
                    fill_data  = hub_word(base + i);
                    @(negedge clk);
                end
                fill_valid = 1'b0;
            end
        end
    end

    // reference model of the replacement state
    int m_tag[4];
    bit m_val[4];
    int m_q[4];

    task automatic mdl_reset();
        for (int l = 0; l < 4; l++) begin
            m_val[l] = 0; m_tag[l] = 0; m_q[l] = l;
        end
    endtask

    function automatic bit mdl_access(input int wide, input int tk);
        int v;
        if (split_mode) begin
            if (m_val[tk] && m_tag[tk] == wide) return 1;
            m_val[tk] = 1; m_tag[tk] = wide;
            return 0;
        end
        for (int l = 0; l < 4; l++) begin
            if (m_val[l] && m_tag[l] == wide) begin
                int p;
                p = 0;
                for (int j = 0; j < 4; j++) if (m_q[j] == l) p = j;
                for (int j = p; j < 3; j++) m_q[j] = m_q[j+1];
                m_q[3] = l;
                return 1;
            end
        end
        v = m_q[0];
        for (int j = 0; j < 3; j++) m_q[j] = m_q[j+1];
        m_q[3] = v;
        m_val[v] = 1; m_tag[v] = wide;
        return 0;
    endfunction

    task automatic apply_reset(input bit mode);
        @(negedge clk);
        fetch_valid = 1'b0;
        rst = 1'b1;
        split_mode = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_reset();
        #1;
        chk(fill_req == 1'b0, "R2", "fill_req after reset", fill_req, 0);
        chk(fetch_hit == 1'b0, "R9", "hit without request", fetch_hit, 0);
    endtask

    // one fetch; returns 1 when it hit on the first cycle
    task automatic do_fetch(input int addr, input int tk, input string req, output bit was_hit);
        bit exp_hit, stalled;
        int stall_cyc;
        exp_hit = mdl_access(addr / 8, tk);
        stalled = 0;
        stall_cyc = 0;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = ADDR_W'(addr);
        fetch_task  = 2'(tk);
        forever begin
            #2;
            if (fetch_hit) break;
            if (!stalled) chk(fetch_stall == 1'b1, "R9", "stall on miss", fetch_stall, 1);
            if (stall_cyc == 1) chk(fill_req && fill_wide_addr == TAG_W'(addr / 8), "R3",
                                    "fill wide address", int'(fill_wide_addr), addr / 8);
            stalled = 1;
            stall_cyc++;
            @(negedge clk);
        end
        chk(fetch_stall == 1'b0, "R9", "no stall with hit", fetch_stall, 0);
        chk(fetch_data == hub_word(addr), stalled ? "R4" : "R1", "fetch data",
            int'(fetch_data), int'(hub_word(addr)));
        chk(stalled == !exp_hit, req, "miss expected", stalled, !exp_hit);
        if (stalled) chk(stall_cyc >= 10, "R3", "full wide before hit", stall_cyc, 10);
        was_hit = !stalled;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic expect_fetch(input int wide, input int off, input int tk, input bit hit, input string req);
        bit h;
        do_fetch(wide * 8 + off, tk, req, h);
        chk(h == hit, req, $sformatf("wide %0d hit", wide), h, hit);
    endtask

    initial begin
        int seed;
        bit h;
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish");
        errors++; checks++;
        summary();
        $finish;
    end

    initial begin
        int s;
        bit h;

        // R2, R1: reset state, cold miss, every offset of one wide
        apply_reset(1'b0);
        expect_fetch(100, 5, 0, 0, "R2");
        for (int o = 0; o < 8; o++) expect_fetch(100, o, 0, 1, "R1");

        // R5: round-robin from reset
        apply_reset(1'b0);
        for (int w = 0; w < 4; w++) expect_fetch(10 + w, w, 0, 0, "R5");
        expect_fetch(14, 0, 0, 0, "R5");
        expect_fetch(11, 1, 0, 1, "R5");
        expect_fetch(12, 2, 0, 1, "R5");
        expect_fetch(13, 3, 0, 1, "R5");
        expect_fetch(10, 0, 0, 0, "R5");

        // R6: a hit protects the oldest wide
        apply_reset(1'b0);
        for (int w = 0; w < 4; w++) expect_fetch(20 + w, 7, 0, 0, "R6");
        expect_fetch(20, 2, 0, 1, "R6");
        expect_fetch(24, 2, 0, 0, "R6");
        expect_fetch(20, 4, 0, 1, "R6");
        expect_fetch(22, 4, 0, 1, "R6");
        expect_fetch(23, 4, 0, 1, "R6");
        expect_fetch(21, 4, 0, 0, "R6");
        expect_fetch(24, 4, 0, 0, "R6");

        // R7: split mode, one line per task
        apply_reset(1'b1);
        expect_fetch(30, 0, 0, 0, "R7");
        expect_fetch(31, 1, 1, 0, "R7");
        expect_fetch(32, 2, 0, 0, "R7");
        expect_fetch(31, 3, 1, 1, "R7");
        expect_fetch(30, 0, 0, 0, "R7");
        expect_fetch(30, 0, 2, 0, "R7");
        expect_fetch(30, 6, 0, 1, "R7");

        // R6, R8: shared sweep over six wides
        apply_reset(1'b0);
        s = 7;
        for (int i = 0; i < 300; i++) begin
            s = (s * 1103515245 + 12345) & 32'h7fff_ffff;
            do_fetch(((s >> 8) % 6 + 40) * 8 + (s >> 4) % 8, 0, "R6", h);
        end

        // R7: split sweep
        apply_reset(1'b1);
        for (int i = 0; i < 200; i++) begin
            s = (s * 1103515245 + 12345) & 32'h7fff_ffff;
            do_fetch(((s >> 8) % 5 + 60) * 8 + (s >> 4) % 8, i % 4, "R7", h);
        end

        summary();
        $finish;
    end
endmodule